// File: doc/BRIEF.md
# Colour Subcarrier Synthesizer with Quadrature Chroma Modulator

This block produces the chrominance component of a composite video signal. A 32-bit phase accumulator advances by a programmable frequency word on every pixel clock to form the colour subcarrier. The upper bits of the accumulator, plus a phase offset, address a computed sine table. The table gives both a sine and a cosine sample. During active video these two samples modulate a pair of signed colour-difference inputs, and the two products are summed into one chroma sample. During the colour burst window the block emits a fixed-amplitude reference sine instead. Outside both windows it emits zero.

The burst window and the active window each have their own phase offset. Changing only the active offset rotates the decoded hue, and the burst reference does not move. The same control also cancels a fixed external phase error. The burst itself is shaped by the caller: its frequency comes from the frequency word, its phase from the burst offset, and its duration from how long the burst window flag is held. A line-start strobe can reload the accumulator with a programmable starting phase. This keeps the subcarrier phase repeatable from line to line.

Top module: `chroma_modulator`

## Requirements
- R1: While reset is asserted the chroma output is 0. After reset the accumulator holds 0, so the first sampled phase is the offset alone.
- R2: When no reload occurs, the accumulator increases by `freq_word` modulo 2^32 on every clock.
- R3: When `line_start` and `resync_en` are both high at a clock edge, the accumulator is loaded with `reset_phase` placed in bits 31:22 and zeros below. The phase sampled at that same edge is still the old one. When `resync_en` is low, `line_start` has no effect.
- R4: The sine table S(p) for a 10-bit phase p is built from a half-wave table H(t) = floor(255·16·t·(512−t) / (5·512² − 4·t·(512−t))) for t in 0..511. S(p) equals H(p[8:0]) when p[9] is 0 and −H(p[8:0]) when p[9] is 1. The cosine is C(p) = S(p+256 mod 1024).
- R5: While `active_win` is high and `burst_win` is low, the output is sat(floor((u·S(a) + v·C(a)) / 64)), where a = acc[31:22] + `active_phase` mod 1024.
- R6: While `burst_win` is high, the output is sat(floor(S(b)·128 / 256)), where b = acc[31:22] + `burst_phase` mod 1024. Burst takes priority over the active window, and `u_in` and `v_in` are ignored.
- R7: While both window flags are low, the output is 0.
- R8: Saturation clamps the output to the symmetric range −511..+511. The code −512 never appears.
- R9: Inputs sampled at clock edge k, together with the accumulator value held before that edge, appear on `chroma_out` after edge k+1. This is a fixed latency of two register stages.
- R10: Changing `active_phase` leaves the burst output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | 32 | Phase increment added every clock |
| reset_phase | input | 10 | Phase loaded into accumulator bits 31:22 on resync |
| resync_en | input | 1 | Enables the reload on `line_start` |
| line_start | input | 1 | Line-start strobe |
| burst_phase | input | 10 | Phase offset used during the burst window |
| active_phase | input | 10 | Phase offset used during active video (hue) |
| burst_win | input | 1 | Burst window flag |
| active_win | input | 1 | Active video window flag |
| u_in | input | 8 | Signed first colour-difference sample |
| v_in | input | 8 | Signed second colour-difference sample |
| chroma_out | output | 10 | Signed, saturated chroma sample |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, 10-bit table phase, 8-bit samples, 9-bit sine, a shift of 6 and a burst gain of 128. With a shift of 6, full-scale colour-difference pairs near 45 degrees exceed ±511, so both saturation limits can be reached. With a 10-bit phase, the frequency words used (2^26, zero, and a negative step) move the table address by whole steps. The bench can then select exact quadrant points, run the phase backwards through zero, and hold the phase still after a resync.

// File: rtl/chroma_pkg.sv
package chroma_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_BURST  = 2'd1,
        MODE_ACTIVE = 2'd2
    } chroma_mode_e;

    // Rational approximation of one half period of a sine, scaled by amp.
    // t runs over 0..half-1; the result is non-negative.
    function automatic int half_sine(input int t, input int half, input int amp);
        longint num;
        longint den;
        num = longint'(amp) * 16 * longint'(t) * longint'(half - t);
        den = 5 * longint'(half) * longint'(half) - 4 * longint'(t) * longint'(half - t);
        return int'(num / den);
    endfunction

endpackage

// File: rtl/subc_phase_gen.sv
module subc_phase_gen
    import chroma_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10,
    parameter int SAMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ACC_W-1:0]         freq_word,
    input  logic [ADDR_W-1:0]        reset_phase,
    input  logic                     reload,
    input  logic [ADDR_W-1:0]        burst_phase,
    input  logic [ADDR_W-1:0]        active_phase,
    input  logic                     burst_win,
    input  logic                     active_win,
    input  logic signed [SAMP_W-1:0] u_in,
    input  logic signed [SAMP_W-1:0] v_in,
    output logic [ADDR_W-1:0]        phase_o,
    output chroma_mode_e             mode_o,
    output logic signed [SAMP_W-1:0] u_o,
    output logic signed [SAMP_W-1:0] v_o
);

    localparam int FRAC_W = ACC_W - ADDR_W;

    typedef struct packed {
        logic [ACC_W-1:0]         acc;
        logic [ADDR_W-1:0]        phase;
        chroma_mode_e             mode;
        logic signed [SAMP_W-1:0] u;
        logic signed [SAMP_W-1:0] v;
        logic                     primed;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        logic [ADDR_W-1:0] offset;
        st_d = st_q;
        if (reload) begin
            st_d.acc = {reset_phase, {FRAC_W{1'b0}}};
        end else begin
            st_d.acc = st_q.acc + freq_word;
        end
        offset   = burst_win ? burst_phase : active_phase;
        st_d.phase = st_q.acc[ACC_W-1 -: ADDR_W] + offset;
        if (burst_win) begin
            st_d.mode = MODE_BURST;
        end else if (active_win) begin
            st_d.mode = MODE_ACTIVE;
        end else begin
            st_d.mode = MODE_IDLE;
        end
        st_d.u      = u_in;
        st_d.v      = v_in;
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign mode_o  = st_q.mode;
    assign u_o     = st_q.u;
    assign v_o     = st_q.v;

    // R2: free-running step when no reload was requested
    p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && !$past(reload)) |-> st_q.acc == $past(st_q.acc) + $past(freq_word));

    // R3: reload places the programmed phase in the top bits
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(reload)) |-> st_q.acc == {$past(reset_phase), {FRAC_W{1'b0}}});

endmodule

// File: rtl/sincos_table.sv
module sincos_table
    import chroma_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SIN_W  = 9
) (
    input  logic [ADDR_W-1:0]       phase_i,
    output logic signed [SIN_W-1:0] sin_o,
    output logic signed [SIN_W-1:0] cos_o
);

    localparam int HALF   = 1 << (ADDR_W - 1);
    localparam int QUART  = 1 << (ADDR_W - 2);
    localparam int AMP    = (1 << (SIN_W - 1)) - 1;
    localparam int HIDX_W = ADDR_W - 1;

    logic signed [SIN_W-1:0] half_tab [HALF];
    logic signed [SIN_W-1:0] wave [2];

    for (genvar g = 0; g < HALF; g++) begin : g_tab
        assign half_tab[g] = SIN_W'(half_sine(g, HALF, AMP));
    end

    // channel 0 reads the sine, channel 1 the same table a quarter turn ahead
    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic [ADDR_W-1:0]       p;
        logic signed [SIN_W-1:0] mag;
        always_comb begin
            p   = phase_i + ADDR_W'(c * QUART);
            mag = half_tab[p[HIDX_W-1:0]];
            wave[c] = p[ADDR_W-1] ? -mag : mag;
        end
    end

    assign sin_o = wave[0];
    assign cos_o = wave[1];

endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
    import chroma_pkg::*;
#(
    parameter int SAMP_W      = 8,
    parameter int SIN_W       = 9,
    parameter int OUT_W       = 10,
    parameter int SCALE_SHIFT = 6,
    parameter int BURST_GAIN  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  chroma_mode_e             mode_i,
    input  logic signed [SAMP_W-1:0] u_i,
    input  logic signed [SAMP_W-1:0] v_i,
    input  logic signed [SIN_W-1:0]  sin_i,
    input  logic signed [SIN_W-1:0]  cos_i,
    output logic signed [OUT_W-1:0]  chroma_o
);

    localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;

    typedef struct packed {
        logic signed [OUT_W-1:0] chroma;
    } mix_t;

    mix_t st_d, st_q;

    always_comb begin
        int raw;
        int clipped;
        st_d = st_q;
        unique case (mode_i)
            MODE_ACTIVE: raw = (int'(u_i) * int'(sin_i) + int'(v_i) * int'(cos_i)) >>> SCALE_SHIFT;
            MODE_BURST:  raw = (int'(sin_i) * BURST_GAIN) >>> 8;
            default:     raw = 0;
        endcase
        if (raw > OUT_MAX) begin
            clipped = OUT_MAX;
        end else if (raw < -OUT_MAX) begin
            clipped = -OUT_MAX;
        end else begin
            clipped = raw;
        end
        st_d.chroma = OUT_W'(clipped);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chroma_o = st_q.chroma;

    // R7: a blanked stage-one sample leads to a zero output
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IDLE) |=> (chroma_o == '0));

    // R8: the most negative code is never produced
    p_sym_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chroma_o != {1'b1, {(OUT_W-1){1'b0}}});

endmodule

// File: rtl/chroma_modulator.sv
module chroma_modulator
    import chroma_pkg::*;
#(
    parameter int ACC_W       = 32,
    parameter int ADDR_W      = 10,
    parameter int SAMP_W      = 8,
    parameter int SIN_W       = 9,
    parameter int OUT_W       = 10,
    parameter int SCALE_SHIFT = 6,
    parameter int BURST_GAIN  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ACC_W-1:0]         freq_word,
    input  logic [ADDR_W-1:0]        reset_phase,
    input  logic                     resync_en,
    input  logic                     line_start,
    input  logic [ADDR_W-1:0]        burst_phase,
    input  logic [ADDR_W-1:0]        active_phase,
    input  logic                     burst_win,
    input  logic                     active_win,
    input  logic signed [SAMP_W-1:0] u_in,
    input  logic signed [SAMP_W-1:0] v_in,
    output logic signed [OUT_W-1:0]  chroma_out
);

    logic                     reload;
    logic [ADDR_W-1:0]        phase_s1;
    chroma_mode_e             mode_s1;
    logic signed [SAMP_W-1:0] u_s1;
    logic signed [SAMP_W-1:0] v_s1;
    logic signed [SIN_W-1:0]  sin_w;
    logic signed [SIN_W-1:0]  cos_w;

    assign reload = line_start & resync_en;

    subc_phase_gen #(
        .ACC_W (ACC_W),
        .ADDR_W(ADDR_W),
        .SAMP_W(SAMP_W)
    ) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .freq_word   (freq_word),
        .reset_phase (reset_phase),
        .reload      (reload),
        .burst_phase (burst_phase),
        .active_phase(active_phase),
        .burst_win   (burst_win),
        .active_win  (active_win),
        .u_in        (u_in),
        .v_in        (v_in),
        .phase_o     (phase_s1),
        .mode_o      (mode_s1),
        .u_o         (u_s1),
        .v_o         (v_s1)
    );

    sincos_table #(
        .ADDR_W(ADDR_W),
        .SIN_W (SIN_W)
    ) u_table (
        .phase_i(phase_s1),
        .sin_o  (sin_w),
        .cos_o  (cos_w)
    );

    quad_mixer #(
        .SAMP_W     (SAMP_W),
        .SIN_W      (SIN_W),
        .OUT_W      (OUT_W),
        .SCALE_SHIFT(SCALE_SHIFT),
        .BURST_GAIN (BURST_GAIN)
    ) u_mix (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_s1),
        .u_i     (u_s1),
        .v_i     (v_s1),
        .sin_i   (sin_w),
        .cos_i   (cos_w),
        .chroma_o(chroma_out)
    );

    // R1: output is held at zero through reset
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |-> chroma_out == '0);

endmodule

// File: tb/tb_chroma_modulator.sv
module tb_chroma_modulator;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       freq_word = '0;
    logic [9:0]        reset_phase = '0;
    logic              resync_en = 1'b0;
    logic              line_start = 1'b0;
    logic [9:0]        burst_phase = '0;
    logic [9:0]        active_phase = '0;
    logic              burst_win = 1'b0;
    logic              active_win = 1'b0;
    logic signed [7:0] u_in = '0;
    logic signed [7:0] v_in = '0;
    logic signed [9:0] chroma_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_acc = '0;
    bit          have_pend = 0;
    int          pend_e = 0;
    string       pend_tag = "";

    always #10 clk = ~clk;

    chroma_modulator dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .freq_word   (freq_word),
        .reset_phase (reset_phase),
        .resync_en   (resync_en),
        .line_start  (line_start),
        .burst_phase (burst_phase),
        .active_phase(active_phase),
        .burst_win   (burst_win),
        .active_win  (active_win),
        .u_in        (u_in),
        .v_in        (v_in),
        .chroma_out  (chroma_out)
    );

    typedef struct packed {
        logic       bw;
        logic       aw;
        logic [7:0] u;
        logic [7:0] v;
        logic [9:0] ap;
        logic [9:0] bp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b1, 8'd100, 8'd0,   10'd0,   10'd0},
        '{1'b0, 1'b1, 8'd0,   8'd100, 10'd0,   10'd0},
        '{1'b0, 1'b1, 8'hCE,  8'd70,  10'd100, 10'd0},
        '{1'b0, 1'b0, 8'd127, 8'd127, 10'd0,   10'd0},
        '{1'b1, 1'b0, 8'd0,   8'd0,   10'd0,   10'd0},
        '{1'b1, 1'b0, 8'd0,   8'd0,   10'd0,   10'd512},
        '{1'b0, 1'b1, 8'd90,  8'hA6,  10'd256, 10'd0},
        '{1'b1, 1'b1, 8'd127, 8'd127, 10'd40,  10'd300},
        '{1'b0, 1'b1, 8'd127, 8'd127, 10'd128, 10'd0},
        '{1'b0, 1'b0, 8'd0,   8'd0,   10'd0,   10'd0},
        '{1'b1, 1'b0, 8'd5,   8'd9,   10'd0,   10'd700},
        '{1'b0, 1'b1, 8'h80,  8'h80,  10'd384, 10'd0}
    };

    function automatic int half_ref(input int t);
        longint num;
        longint den;
        num = 255 * 16 * longint'(t) * longint'(512 - t);
        den = 5 * 512 * 512 - 4 * longint'(t) * longint'(512 - t);
        return int'(num / den);
    endfunction

    function automatic int sin_ref(input logic [9:0] p);
        return p[9] ? -half_ref(int'(p[8:0])) : half_ref(int'(p[8:0]));
    endfunction

    function automatic int clip(input int x);
        if (x > 511) return 511;
        if (x < -511) return -511;
        return x;
    endfunction

    function automatic int expect_now(input logic bw, input logic aw,
                                      input logic [7:0] u, input logic [7:0] v,
                                      input logic [9:0] ap, input logic [9:0] bp);
        logic [9:0] top;
        logic [9:0] p;
        top = m_acc[31:22];
        if (bw) begin
            p = top + bp;
            return clip((sin_ref(p) * 128) >>> 8);
        end else if (aw) begin
            p = top + ap;
            return clip((int'($signed(u)) * sin_ref(p) +
                         int'($signed(v)) * sin_ref(p + 10'd256)) >>> 6);
        end
        return 0;
    endfunction

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: chroma_out got %0d expected %0d", tag, got, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare the sample issued one cycle earlier
    task automatic cyc(input logic bw, input logic aw, input logic ls,
                       input logic [7:0] u, input logic [7:0] v,
                       input logic [9:0] ap, input logic [9:0] bp,
                       input string tag);
        int e;
        burst_win    = bw;
        active_win   = aw;
        line_start   = ls;
        u_in         = u;
        v_in         = v;
        active_phase = ap;
        burst_phase  = bp;
        e = expect_now(bw, aw, u, v, ap, bp);
        if (ls && resync_en) m_acc = {reset_phase, 22'd0};
        else m_acc = m_acc + freq_word;
        @(posedge clk);
        @(negedge clk);
        if (have_pend) check(int'(chroma_out), pend_e, pend_tag);
        pend_e    = e;
        pend_tag  = tag;
        have_pend = 1;
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 10'd0, 10'd0, tag);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(int'(chroma_out), 0, "R1 during reset");
        rst_n = 1'b1;
        // R1: accumulator starts at zero, freq zero keeps it there
        cyc(1'b0, 1'b1, 1'b0, 8'd0, 8'd64, 10'd0, 10'd0, "R1 first phase");
        idle("R7 after first");

        // table-driven pass with a moving subcarrier (R5 R6 R7 R9)
        freq_word = 32'h0400_0000;
        for (int i = 0; i < 12; i++) begin
            cyc(VEC[i].bw, VEC[i].aw, 1'b0, VEC[i].u, VEC[i].v, VEC[i].ap, VEC[i].bp,
                VEC[i].bw ? "R6 vector" : (VEC[i].aw ? "R5 R9 vector" : "R7 vector"));
        end
        idle("R7 flush");

        // R3: resync reloads; sample at the strobe edge still uses the old phase
        resync_en   = 1'b1;
        reset_phase = 10'd256;
        cyc(1'b0, 1'b1, 1'b1, 8'd100, 8'd0, 10'd0, 10'd0, "R3 strobe cycle");
        cyc(1'b0, 1'b1, 1'b0, 8'd100, 8'd0, 10'd0, 10'd0, "R3 after reload");
        // R3: strobe ignored with resync disabled
        resync_en = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 8'd100, 8'd0, 10'd0, 10'd0, "R3 disabled strobe");
        cyc(1'b0, 1'b1, 1'b0, 8'd100, 8'd0, 10'd0, 10'd0, "R3 disabled follow");

        // R4: frozen phase, table quadrant points
        resync_en   = 1'b1;
        reset_phase = 10'd0;
        freq_word   = 32'd0;
        cyc(1'b0, 1'b0, 1'b1, 8'd0, 8'd0, 10'd0, 10'd0, "R7 resync to zero");
        resync_en = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 8'd64, 8'd0, 10'd256, 10'd0, "R4 sine peak");
        cyc(1'b0, 1'b1, 1'b0, 8'd64, 8'd0, 10'd768, 10'd0, "R4 sine trough");
        cyc(1'b0, 1'b1, 1'b0, 8'd64, 8'd0, 10'd77,  10'd0, "R4 sine mid");
        cyc(1'b0, 1'b1, 1'b0, 8'd0, 8'd64, 10'd512, 10'd0, "R4 cosine negative");

        // R8: saturation both ways
        cyc(1'b0, 1'b1, 1'b0, 8'd127, 8'd127, 10'd128, 10'd0, "R8 positive clip");
        cyc(1'b0, 1'b1, 1'b0, 8'h80,  8'h80,  10'd128, 10'd0, "R8 negative clip");

        // R10: hue offset does not move the burst; u and v ignored (R6)
        cyc(1'b1, 1'b0, 1'b0, 8'd0,   8'd0,  10'd0,   10'd200, "R10 burst ref");
        cyc(1'b1, 1'b1, 1'b0, 8'h80,  8'd99, 10'd500, 10'd200, "R10 burst with hue moved");
        cyc(1'b1, 1'b1, 1'b0, 8'd127, 8'h81, 10'd900, 10'd200, "R6 burst ignores u v");

        // R2: negative step wraps the accumulator through zero
        freq_word = 32'hFFC0_0000;
        for (int k = 0; k < 4; k++) begin
            cyc(1'b0, 1'b1, 1'b0, 8'd50, 8'd50, 10'd3, 10'd0, "R2 wrap step");
        end

        // R9: lone active sample between blanks
        freq_word = 32'h0123_4567;
        idle("R7 before lone");
        cyc(1'b0, 1'b1, 1'b0, 8'd120, 8'hC0, 10'd45, 10'd0, "R9 lone sample");
        idle("R9 after lone");
        idle("R7 tail");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule